// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Per-Pin Event Steering

This block is an eight-pin general-purpose I/O port for a larger chip. Software drives the pins through an output data register and reads them back through a synchronised input register. Each pin can also raise an event on a rising edge of its synchronised input. An event is latched in a sticky status bit that software clears by writing a 1 to it.

Every pin has its own small routing register. This register decides whether the pin's latched event drives the interrupt request output, the system-management interrupt output, both, or neither. The eight routing registers are not mapped side by side. Software first writes a pin number into an index register, then reads or writes the chosen pin's routing register through a single data port.

A build parameter removes the event machinery and leaves a plain data port. In that variant the routing, enable and status locations read as zero and the two interrupt outputs stay low.

Top module: `gpio_evt_port`

## Requirements
- R1: After a synchronous active-high reset: output data is 0x00, event enable is 0x00, event status is 0x00, the index is 0, every routing register is 0x01, and irq_o and smi_o are low.
- R2: Offset 0 is the output data register. A write sets pin_out on the following edge, and a read returns the stored value.
- R3: Offset 1 is read-only and returns pin_in after a two-flop synchroniser. A pin change that is set up before clock edge k reads back after edge k+1. Writes to offset 1 have no effect.
- R4: Offset 4 is the pin index (bits 2:0; it reads back in bits 2:0, upper bits 0). Offset 5 accesses the routing register of the indexed pin: bit 0 = route to IRQ, bit 1 = route to SMI. Bits 7:2 read 0 and ignore writes.
- R5: A rising edge on a synchronised input sets that pin's status bit (offset 3, bit n for pin n) only when event enable bit n (offset 2) is 1. A falling edge sets nothing.
- R6: A status bit stays set until a write to offset 3 with a 1 in that bit position. Writing 0 leaves the bit unchanged.
- R7: irq_o is the OR over all pins of status AND IRQ route, and smi_o is the OR over all pins of status AND SMI route. Both are levels that fall once the contributing status bits are cleared.
- R8: If an event sets a status bit in the same cycle as a write-1-to-clear of that bit, the bit ends set.
- R9: Offsets 6 and 7 read 0.
- R10: With HAS_EVENTS = 0, offsets 2, 3 and 5 read 0, writes there have no effect, and irq_o and smi_o stay low. Data out and data in still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous pin input levels |
| pin_out | output | 8 | Output data driven to the pins |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| irq_o | output | 1 | Interrupt request level |
| smi_o | output | 1 | System-management interrupt level |

## Verification
On every cycle, the assertions check several properties. A status bit never drops without a matching clear, and never rises without its enable. An enabled edge is never lost to a simultaneous clear. Reserved routing bits always read zero, and both interrupt outputs are low whenever no status bit is set. Only the bench scenarios can show the remaining behaviour: the exact synchroniser latency, the steering of each pin through the index register to the correct output, and the reset values. They also show the inert behaviour of the basic variant.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int NPINS = 8;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int IDXW  = $clog2(NPINS);

    typedef enum logic [AW-1:0] {
        OFS_DOUT  = 3'd0,
        OFS_DIN   = 3'd1,
        OFS_EVEN  = 3'd2,
        OFS_EVST  = 3'd3,
        OFS_INDEX = 3'd4,
        OFS_ROUTE = 3'd5
    } ofs_e;

    typedef struct packed {
        logic smi;
        logic irq;
    } route_t;

    localparam route_t ROUTE_RESET = '{smi: 1'b0, irq: 1'b1};

    function automatic logic [DW-1:0] route_to_byte(input route_t r);
        return {{(DW-2){1'b0}}, r.smi, r.irq};
    endfunction

    function automatic route_t byte_to_route(input logic [DW-1:0] b);
        return '{smi: b[1], irq: b[0]};
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    input  logic [W-1:0] evt_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status_q
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;

    assign rise = level & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            prev_q   <= level;
            status_q <= (status_q & ~clr_mask) | (rise & evt_en);
        end
    end

    // R6: a set bit survives unless its clear was written
    a_r6_status_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status_q) & ~$past(clr_mask)) & ~status_q) == '0));

    // R5: a bit cannot become set while its enable is low
    a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_en)) == '0));

    // R8: an enabled edge always lands, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(rise) & $past(evt_en)) & ~status_q) == '0));
endmodule

// File: rtl/gpio_route_bank.sv
module gpio_route_bank
    import gpio_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            idx_we,
    input  logic            route_we,
    input  logic [DW-1:0]   wdata,
    output logic [IDXW-1:0] idx_q,
    output logic [DW-1:0]   route_rd,
    output logic [NPINS-1:0] irq_route,
    output logic [NPINS-1:0] smi_route
);
    route_t entries [NPINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_we) begin
            idx_q <= wdata[IDXW-1:0];
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[p] <= ROUTE_RESET;
            end else if (route_we && (idx_q == IDXW'(p))) begin
                entries[p] <= byte_to_route(wdata);
            end
        end
        assign irq_route[p] = entries[p].irq;
        assign smi_route[p] = entries[p].smi;
    end

    assign route_rd = route_to_byte(entries[idx_q]);
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port
    import gpio_evt_pkg::*;
#(
    parameter bit HAS_EVENTS = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq_o,
    output logic             smi_o
);
    logic [NPINS-1:0] din_sync;
    logic [NPINS-1:0] evt_en_q;
    logic [NPINS-1:0] status;
    logic [NPINS-1:0] irq_route;
    logic [NPINS-1:0] smi_route;
    logic [IDXW-1:0]  idx_q;
    logic [DW-1:0]    route_rd;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(din_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_out <= '0;
        end else if (wr_en && addr == OFS_DOUT) begin
            pin_out <= wdata[NPINS-1:0];
        end
    end

    if (HAS_EVENTS) begin : g_evt
        logic [NPINS-1:0] clr_mask;

        always_ff @(posedge clk) begin
            if (rst) begin
                evt_en_q <= '0;
            end else if (wr_en && addr == OFS_EVEN) begin
                evt_en_q <= wdata[NPINS-1:0];
            end
        end

        assign clr_mask = (wr_en && addr == OFS_EVST) ? wdata[NPINS-1:0] : '0;

        gpio_evt_detect #(.W(NPINS)) u_det (
            .clk(clk), .rst(rst), .level(din_sync), .evt_en(evt_en_q),
            .clr_mask(clr_mask), .status_q(status)
        );

        gpio_route_bank u_route (
            .clk(clk), .rst(rst),
            .idx_we(wr_en && addr == OFS_INDEX),
            .route_we(wr_en && addr == OFS_ROUTE),
            .wdata(wdata), .idx_q(idx_q), .route_rd(route_rd),
            .irq_route(irq_route), .smi_route(smi_route)
        );
    end else begin : g_basic
        assign evt_en_q  = '0;
        assign status    = '0;
        assign irq_route = '0;
        assign smi_route = '0;
        assign idx_q     = '0;
        assign route_rd  = '0;
    end

    assign irq_o = |(status & irq_route);
    assign smi_o = |(status & smi_route);

    always_comb begin
        unique case (addr)
            OFS_DOUT:  rdata = DW'(pin_out);
            OFS_DIN:   rdata = DW'(din_sync);
            OFS_EVEN:  rdata = DW'(evt_en_q);
            OFS_EVST:  rdata = DW'(status);
            OFS_INDEX: rdata = DW'(idx_q);
            OFS_ROUTE: rdata = route_rd;
            default:   rdata = '0;
        endcase
    end

    // R4: reserved routing bits never read back as 1
    a_r4_route_reserved: assert property (@(posedge clk) disable iff (rst)
        (addr == OFS_ROUTE) |-> (rdata[DW-1:2] == '0));

    // R7: no latched event means both request lines are quiet
    a_r7_quiet_when_clear: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |-> (!irq_o && !smi_o));

    // R9: unused offsets read zero
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (addr > OFS_ROUTE) |-> (rdata == '0));
endmodule

// File: tb/sim_gpio_evt_port.sv
module sim_gpio_evt_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_in = '0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] pin_out, rdata, pin_out_b, rdata_b;
    logic       irq_o, smi_o, irq_b, smi_b;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    gpio_evt_port u0 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_out(pin_out),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_o(irq_o), .smi_o(smi_o)
    );

    gpio_evt_port #(.HAS_EVENTS(1'b0)) u1 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_out(pin_out_b),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata_b),
        .irq_o(irq_b), .smi_o(smi_b)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd0, v); check("R1 dout", v, 8'h00);
        rd(3'd2, v); check("R1 enable", v, 8'h00);
        rd(3'd3, v); check("R1 status", v, 8'h00);
        rd(3'd4, v); check("R1 index", v, 8'h00);
        for (int p = 0; p < 8; p++) begin
            wr(3'd4, 8'(p)); rd(3'd5, v); check("R1 route", v, 8'h01);
        end
        check("R1 irq/smi", {6'b0, irq_o, smi_o}, 8'h00);
    endtask

    task automatic t_data;
        logic [7:0] v;
        wr(3'd0, 8'hA5);
        check("R2 pin_out", pin_out, 8'hA5);
        rd(3'd0, v); check("R2 readback", v, 8'hA5);
        @(negedge clk); pin_in = 8'h3C;
        @(posedge clk); @(negedge clk);
        addr = 3'd1; #1 check("R3 din after one edge", rdata, 8'h00);
        @(posedge clk); @(negedge clk);
        addr = 3'd1; #1 check("R3 din after two edges", rdata, 8'h3C);
        wr(3'd1, 8'hFF);
        rd(3'd1, v); check("R3 write ignored", v, 8'h3C);
        @(negedge clk); pin_in = 8'h00;
        cycles(4);
        rd(3'd6, v); check("R9 offset 6", v, 8'h00);
        rd(3'd7, v); check("R9 offset 7", v, 8'h00);
    endtask

    task automatic t_route_regs;
        logic [7:0] v;
        wr(3'd4, 8'hFB);
        rd(3'd4, v); check("R4 index readback", v, 8'h03);
        wr(3'd5, 8'hFE);
        rd(3'd5, v); check("R4 reserved bits", v, 8'h02);
        wr(3'd4, 8'h02);
        rd(3'd5, v); check("R4 other pin untouched", v, 8'h01);
        wr(3'd4, 8'h03);
        rd(3'd5, v); check("R4 pin3 kept", v, 8'h02);
    endtask

    task automatic t_events;
        logic [7:0] v;
        // pin3 routed SMI only, pin0 default IRQ
        wr(3'd2, 8'h08);
        @(negedge clk); pin_in = 8'h01;
        cycles(4);
        rd(3'd3, v); check("R5 disabled pin no event", v, 8'h00);
        @(negedge clk); pin_in = 8'h09;
        cycles(4);
        rd(3'd3, v); check("R5 enabled edge sets", v, 8'h08);
        check("R7 smi only", {6'b0, irq_o, smi_o}, 8'h01);
        @(negedge clk); pin_in = 8'h01;
        cycles(4);
        wr(3'd3, 8'hF7);
        rd(3'd3, v); check("R6 write0 keeps", v, 8'h08);
        wr(3'd3, 8'h08);
        rd(3'd3, v); check("R6 w1c clears", v, 8'h00);
        check("R7 drops after clear", {6'b0, irq_o, smi_o}, 8'h00);
        // pin0 enabled, default IRQ route
        wr(3'd2, 8'h09);
        @(negedge clk); pin_in = 8'h00;
        cycles(4);
        rd(3'd3, v); check("R5 falling no event", v, 8'h00);
        @(negedge clk); pin_in = 8'h09;
        cycles(4);
        rd(3'd3, v); check("R5 two pins", v, 8'h09);
        check("R7 both lines", {6'b0, irq_o, smi_o}, 8'h03);
        wr(3'd3, 8'h01);
        check("R7 irq dropped", {6'b0, irq_o, smi_o}, 8'h01);
        // set vs clear in the same cycle on pin3
        @(negedge clk); pin_in = 8'h01;
        cycles(4);
        @(negedge clk); pin_in = 8'h09;
        @(posedge clk); @(posedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 3'd3; wdata = 8'h08;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        rd(3'd3, v); check("R8 set wins", v, 8'h08);
        wr(3'd3, 8'hFF);
    endtask

    task automatic t_basic;
        wr(3'd2, 8'hFF);
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h03);
        @(negedge clk); pin_in = 8'h00;
        cycles(4);
        @(negedge clk); pin_in = 8'hFF;
        cycles(4);
        addr = 3'd2; #1 check("R10 enable reads 0", rdata_b, 8'h00);
        addr = 3'd3; #1 check("R10 status reads 0", rdata_b, 8'h00);
        addr = 3'd5; #1 check("R10 route reads 0", rdata_b, 8'h00);
        addr = 3'd1; #1 check("R10 din works", rdata_b, 8'hFF);
        check("R10 outputs low", {6'b0, irq_b, smi_b}, 8'h00);
        check("R10 dout works", pin_out_b, 8'hA5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_data();
        t_route_regs();
        t_events();
        t_basic();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule